// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This peripheral is a countdown watchdog with a small register window, 16 bits wide and byte-addressed. It holds a 10-bit timeout value and counts down by one on each tick strobe that arrives while the timer is not halted. Software keeps the system alive by writing to the reload register before the count runs out.

When the count runs out the first time, the block sets a timeout flag and can raise an interrupt. It then reloads itself and counts the same period again. If the count runs out a second time while the first flag is still set, the block sets a second-timeout flag and issues a one-cycle reset request. A no-reboot control bit can withhold that request. Clearing the first flag in time restarts the two-stage sequence.

All status flags are write-one-to-clear. Timeout values below 4 are rejected and leave the stored value as it was. The halt bit and the no-reboot bit are both set out of reset, so the timer starts halted and harmless.

Top module: `dual_expiry_wdt`

## Requirements
- R1: After reset the control register (offset 0x08) reads 0x0810, which means halt bit 11 = 1, no-reboot bit 4 = 1 and interrupt-enable bit 0 = 0. The timeout register (0x12) reads 50 and the count (0x00) reads 50. Both status registers (0x04, 0x06) read 0, and irq and rst_req are low.
- R2: A write of any data to offset 0x00 loads the count from the low 10 bits of the timeout register. A read of offset 0x00 returns the current count in bits 9:0, with the upper bits zero.
- R3: The timeout register at offset 0x12 stores all 16 written bits. Only bits 9:0 set the count period, so upper bits written there do not change the value loaded by a reload.
- R4: A write to offset 0x12 whose bits 9:0 are 0 to 3 is ignored, and the previous 16-bit value stays in place.
- R5: The count drops by one per cycle with tick_en high while halt bit 11 of 0x08 is 0. With the halt bit set, ticks leave the count unchanged. The halt bit reads back as written.
- R6: On a tick with count 1 and bit 3 of 0x04 clear, bit 3 of 0x04 is set and the count reloads from the timeout value. Writing 1 to bit 3 clears it, and writing 0 to it leaves it unchanged.
- R7: irq is high exactly while bit 3 of 0x04 and interrupt-enable bit 0 of 0x08 are both 1.
- R8: On a tick with count 1 while bit 3 of 0x04 is set, bit 1 of 0x06 is set and the count goes to 0. It stays at 0 until a write to 0x00. rst_req is high for exactly the one cycle after that tick edge.
- R9: If bit 3 of 0x04 is cleared before the next expiry, that expiry counts as a first expiry again and no reset is requested.
- R10: When no-reboot bit 4 of 0x08 is 1, a second expiry sets bit 1 of 0x06 but rst_req stays low.
- R11: Bit 2 of 0x06 is set together with each issued reset request and is not set when the request is suppressed. Writing 1 to bits 1 or 2 of 0x06 clears the corresponding bit, and writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Count strobe, one decrement per cycle high |
| bus_addr | input | 5 | Byte address of the selected register |
| bus_wr | input | 1 | Write strobe for bus_addr and bus_wdata |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt request, level |
| rst_req | output | 1 | Reset request, single-cycle pulse |

## Verification
Register writes and ticks take effect at the clock edge they are presented on. Their results can be read back combinationally from the next cycle on. The reset request is a registered pulse that is high only in the cycle right after the edge where the second expiry's tick was taken.

The bench drives every stimulus on a falling edge and queues each expectation. It samples just after the following falling edge, so the rst_req check lands inside its one-cycle window, and a second check one cycle later confirms it has dropped.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] ADDR_RELOAD = 5'h00;
  localparam logic [ADDR_W-1:0] ADDR_STAT1  = 5'h04;
  localparam logic [ADDR_W-1:0] ADDR_STAT2  = 5'h06;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 5'h08;
  localparam logic [ADDR_W-1:0] ADDR_TMO    = 5'h12;

  localparam int unsigned BIT_FIRST_TO  = 3;
  localparam int unsigned BIT_SECOND_TO = 1;
  localparam int unsigned BIT_BOOT      = 2;
  localparam int unsigned BIT_HALT      = 11;
  localparam int unsigned BIT_NOREBOOT  = 4;
  localparam int unsigned BIT_IRQ_EN    = 0;

  typedef struct packed {
    logic halt;
    logic no_reboot;
    logic irq_en;
  } wdt_ctrl_t;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W        = 10,
  parameter int unsigned INIT_DEFAULT = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             halt,
  input  logic             reload_wr,
  input  logic [CNT_W-1:0] tmo_val,
  input  logic             first_pending,
  output logic [CNT_W-1:0] count,
  output logic             exp_first,
  output logic             exp_second
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step, hit, cnt_en;

  always_comb begin
    step       = tick_en && !halt && (cnt_q != '0);
    hit        = step && !reload_wr && (cnt_q == CNT_W'(1));
    exp_first  = hit && !first_pending;
    exp_second = hit && first_pending;
    cnt_en     = reload_wr || step;
    cnt_d      = cnt_q;
    if (reload_wr)      cnt_d = tmo_val;
    else if (exp_first) cnt_d = tmo_val;
    else if (step)      cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_W'(INIT_DEFAULT);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R5
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !reload_wr) |=> $stable(cnt_q));
  // R8
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !reload_wr) |=> (cnt_q == '0));
  // R2
  reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_wr |=> (cnt_q == $past(tmo_val)));
endmodule

// File: rtl/wdt_resetgen.sv
module wdt_resetgen (
  input  logic clk,
  input  logic rst_n,
  input  logic exp_second,
  input  logic no_reboot,
  output logic boot_set,
  output logic rst_req
);
  logic req_q, req_d;

  always_comb begin
    boot_set = exp_second && !no_reboot;
    req_d    = boot_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign rst_req = req_q;

  // R8
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R10
  noreboot_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !$past(no_reboot));
  // R8
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(exp_second));
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W        = 10,
  parameter int unsigned INIT_DEFAULT = 50,
  parameter int unsigned INIT_MIN     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              exp_first,
  input  logic              exp_second,
  input  logic              boot_set,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [CNT_W-1:0]  tmo_val,
  output wdt_ctrl_t         ctrl,
  output logic              reload_wr,
  output logic              first_flag,
  output logic              irq
);
  logic [DATA_W-1:0] tmo_q, tmo_d;
  wdt_ctrl_t         ctrl_q, ctrl_d;
  logic              f1_q, f1_d, f2_q, f2_d, boot_q, boot_d;
  logic              wr_tmo, wr_ctrl, wr_s1, wr_s2, tmo_ok;

  // write decode
  always_comb begin
    reload_wr = bus_wr && (bus_addr == ADDR_RELOAD);
    wr_tmo    = bus_wr && (bus_addr == ADDR_TMO);
    wr_ctrl   = bus_wr && (bus_addr == ADDR_CTRL);
    wr_s1     = bus_wr && (bus_addr == ADDR_STAT1);
    wr_s2     = bus_wr && (bus_addr == ADDR_STAT2);
    tmo_ok    = bus_wdata[CNT_W-1:0] >= CNT_W'(INIT_MIN);
  end

  // next state: hardware set beats software clear
  always_comb begin
    tmo_d  = tmo_q;
    ctrl_d = ctrl_q;
    if (wr_tmo && tmo_ok) tmo_d = bus_wdata;
    if (wr_ctrl) begin
      ctrl_d.halt      = bus_wdata[BIT_HALT];
      ctrl_d.no_reboot = bus_wdata[BIT_NOREBOOT];
      ctrl_d.irq_en    = bus_wdata[BIT_IRQ_EN];
    end
    f1_d = f1_q;
    if (wr_s1 && bus_wdata[BIT_FIRST_TO]) f1_d = 1'b0;
    if (exp_first)                        f1_d = 1'b1;
    f2_d = f2_q;
    if (wr_s2 && bus_wdata[BIT_SECOND_TO]) f2_d = 1'b0;
    if (exp_second)                        f2_d = 1'b1;
    boot_d = boot_q;
    if (wr_s2 && bus_wdata[BIT_BOOT]) boot_d = 1'b0;
    if (boot_set)                     boot_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q            <= DATA_W'(INIT_DEFAULT);
      ctrl_q.halt      <= 1'b1;
      ctrl_q.no_reboot <= 1'b1;
      ctrl_q.irq_en    <= 1'b0;
      f1_q             <= 1'b0;
      f2_q             <= 1'b0;
      boot_q           <= 1'b0;
    end else begin
      if (wr_tmo)  tmo_q  <= tmo_d;
      if (wr_ctrl) ctrl_q <= ctrl_d;
      f1_q   <= f1_d;
      f2_q   <= f2_d;
      boot_q <= boot_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_RELOAD: bus_rdata[CNT_W-1:0] = count;
      ADDR_STAT1:  bus_rdata[BIT_FIRST_TO] = f1_q;
      ADDR_STAT2: begin
        bus_rdata[BIT_SECOND_TO] = f2_q;
        bus_rdata[BIT_BOOT]      = boot_q;
      end
      ADDR_CTRL: begin
        bus_rdata[BIT_HALT]     = ctrl_q.halt;
        bus_rdata[BIT_NOREBOOT] = ctrl_q.no_reboot;
        bus_rdata[BIT_IRQ_EN]   = ctrl_q.irq_en;
      end
      ADDR_TMO:    bus_rdata = tmo_q;
      default:     bus_rdata = '0;
    endcase
  end

  assign tmo_val    = tmo_q[CNT_W-1:0];
  assign ctrl       = ctrl_q;
  assign first_flag = f1_q;
  assign irq        = f1_q && ctrl_q.irq_en;

  // R4
  tmo_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tmo && bus_wdata[CNT_W-1:0] < CNT_W'(INIT_MIN)) |=> $stable(tmo_q));
  // R6
  first_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exp_first |=> f1_q);
  // R8
  second_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exp_second |=> (f2_q && f1_q));
  // R11
  boot_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_set |=> boot_q);
endmodule

// File: rtl/dual_expiry_wdt.sv
module dual_expiry_wdt
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W        = 10,
  parameter int unsigned INIT_DEFAULT = 50,
  parameter int unsigned INIT_MIN     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              rst_req
);
  logic             srst_n;
  logic [CNT_W-1:0] count, tmo_val;
  wdt_ctrl_t        ctrl;
  logic             reload_wr, first_flag, exp_first, exp_second, boot_set;

  wdt_rst_sync u_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  wdt_regs #(
    .CNT_W        (CNT_W),
    .INIT_DEFAULT (INIT_DEFAULT),
    .INIT_MIN     (INIT_MIN)
  ) u_regs (
    .clk        (clk),
    .rst_n      (srst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .count      (count),
    .exp_first  (exp_first),
    .exp_second (exp_second),
    .boot_set   (boot_set),
    .bus_rdata  (bus_rdata),
    .tmo_val    (tmo_val),
    .ctrl       (ctrl),
    .reload_wr  (reload_wr),
    .first_flag (first_flag),
    .irq        (irq)
  );

  wdt_counter #(
    .CNT_W        (CNT_W),
    .INIT_DEFAULT (INIT_DEFAULT)
  ) u_cnt (
    .clk           (clk),
    .rst_n         (srst_n),
    .tick_en       (tick_en),
    .halt          (ctrl.halt),
    .reload_wr     (reload_wr),
    .tmo_val       (tmo_val),
    .first_pending (first_flag),
    .count         (count),
    .exp_first     (exp_first),
    .exp_second    (exp_second)
  );

  wdt_resetgen u_rgen (
    .clk        (clk),
    .rst_n      (srst_n),
    .exp_second (exp_second),
    .no_reboot  (ctrl.no_reboot),
    .boot_set   (boot_set),
    .rst_req    (rst_req)
  );

  // R7
  irq_level_chk: assert property (@(posedge clk) disable iff (!srst_n)
    irq |-> (first_flag && ctrl.irq_en));
  // R9
  no_req_first_chk: assert property (@(posedge clk) disable iff (!srst_n)
    exp_first |=> !rst_req);
endmodule

// File: tb/dual_expiry_wdt_bench.sv
module dual_expiry_wdt_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en;
  logic [4:0]  bus_addr;
  logic        bus_wr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        irq, rst_req;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  typedef struct {
    int          sel;   // 0 bus read, 1 irq, 2 rst_req
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  dual_expiry_wdt u_dual_expiry_wdt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .rst_req   (rst_req)
  );

  // monitor: pops one expectation per cycle, just after the falling edge
  always @(negedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = sb_q.pop_front();
      case (it.sel)
        1:       act = {15'b0, irq};
        2:       act = {15'b0, rst_req};
        default: act = bus_rdata;
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual 0x%04h expected 0x%04h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_reg(input logic [4:0] a, input logic [15:0] e, input string tag);
    item_t it;
    bus_addr = a;
    it.sel = 0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic expect_pin(input int sel, input logic e, input string tag);
    item_t it;
    it.sel = sel; it.exp = {15'b0, e}; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    expect_reg(5'h08, 16'h0810, "R1 ctrl");
    expect_reg(5'h12, 16'd50,   "R1 timeout");
    expect_reg(5'h00, 16'd50,   "R1 count");
    expect_reg(5'h04, 16'h0000, "R1 stat1");
    expect_reg(5'h06, 16'h0000, "R1 stat2");
    expect_pin(1, 1'b0, "R1 irq");
    expect_pin(2, 1'b0, "R1 rst_req");

    // R4 small values rejected
    wr(5'h12, 16'h0003);
    expect_reg(5'h12, 16'd50, "R4 reject 3");
    wr(5'h12, 16'hFC00);
    expect_reg(5'h12, 16'd50, "R4 reject 0 upper set");
    // R3 upper bits kept, no effect on period
    wr(5'h12, 16'hFC05);
    expect_reg(5'h12, 16'hFC05, "R3 stored");
    expect_reg(5'h00, 16'd50,   "R2 count unchanged before reload");
    wr(5'h00, 16'h0000);
    expect_reg(5'h00, 16'd5,    "R2 R3 reload low bits");

    // R5 halted
    ticks(3);
    expect_reg(5'h00, 16'd5, "R5 halted count");

    // run with irq enabled, reset allowed
    wr(5'h08, 16'h0001);
    expect_reg(5'h08, 16'h0001, "R5 halt readback 0");
    ticks(1);
    expect_reg(5'h00, 16'd4, "R5 decrement");
    ticks(4);
    expect_reg(5'h04, 16'h0008, "R6 first flag");
    expect_reg(5'h00, 16'd5,    "R6 reload after first");
    expect_pin(1, 1'b1, "R7 irq high");
    expect_pin(2, 1'b0, "R6 no reset on first");

    // R6 W1C, R9 restart of sequence
    wr(5'h04, 16'h0000);
    expect_reg(5'h04, 16'h0008, "R6 write 0 keeps");
    wr(5'h04, 16'h0008);
    expect_reg(5'h04, 16'h0000, "R6 w1c");
    expect_pin(1, 1'b0, "R7 irq low");
    ticks(5);
    expect_pin(2, 1'b0, "R9 no reset after clear");
    expect_reg(5'h06, 16'h0000, "R9 stat2 clean");
    expect_reg(5'h04, 16'h0008, "R9 first again");

    // R8 R11 second expiry
    ticks(5);
    expect_pin(2, 1'b1, "R8 rst pulse");
    expect_pin(2, 1'b0, "R8 rst single cycle");
    expect_reg(5'h06, 16'h0006, "R8 R11 stat2");
    expect_reg(5'h00, 16'd0,    "R8 count zero");
    ticks(3);
    expect_reg(5'h00, 16'd0,    "R8 hold zero");
    expect_pin(2, 1'b0, "R8 no repeat");
    wr(5'h06, 16'h0000);
    expect_reg(5'h06, 16'h0006, "R11 write 0 keeps");
    wr(5'h06, 16'h0004);
    expect_reg(5'h06, 16'h0002, "R11 boot w1c");
    wr(5'h06, 16'h0002);
    expect_reg(5'h06, 16'h0000, "R11 second w1c");
    wr(5'h00, 16'h1234);
    expect_reg(5'h00, 16'd5, "R8 reload leaves zero");

    // R10 no-reboot, irq disabled
    wr(5'h04, 16'h0008);
    wr(5'h08, 16'h0010);
    ticks(5);
    expect_reg(5'h04, 16'h0008, "R10 first flag");
    expect_pin(1, 1'b0, "R7 irq masked");
    ticks(5);
    expect_pin(2, 1'b0, "R10 rst suppressed");
    expect_reg(5'h06, 16'h0002, "R10 R11 flag only");
    expect_reg(5'h00, 16'd0, "R10 count zero");

    // R5 halt during count
    wr(5'h08, 16'h0811);
    wr(5'h00, 16'h0000);
    ticks(4);
    expect_reg(5'h00, 16'd5, "R5 halt holds");
    expect_reg(5'h08, 16'h0811, "R5 halt readback");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule